// File: doc/BRIEF.md
# Socket status-change event register

This block keeps a 4-bit sticky record of changes seen on the live status lines of a card socket: the power-cycle state, two card-detect lines and the card status-change line. Each line is brought into the clock domain by a synchronizer and compared against a history flop. Any change sets the matching flag. The flag records only that a change happened, never its direction. Software reads the flags through a small word-indexed read/write port and clears each one by writing 1 to it. It can also set flags on purpose through a separate force word. A mask word selects which flags drive the interrupt line.

The status-change flag has two detection modes, set by the card type. For a 32-bit bus-mastering card it is set only on a rising edge. For a 16-bit card it is set on both edges. The block has two resets. The global reset always clears the flags. The bus reset clears them only while power management is disabled. When the card leaves its own reset, the block raises again any flag whose condition still holds.

Top module: `sock_evt_reg`

## Requirements
- R1: The port has four word indices: 0 = event flags, 1 = mask, 2 = force, 3 = synchronized levels. Read-data bits 31 to 4 are always 0, and write-data bits 31 to 4 have no effect on any word.
- R2: Flag bit 3 (power cycle), bit 2 (card detect 2) and bit 1 (card detect 1) are set on either transition of their input. The flag is readable on the third rising clock edge after the edge that first samples the new level.
- R3: Flag bit 0 (status change) is set only on a rising transition when `card_is_cb` = 1, and on both transitions when `card_is_cb` = 0.
- R4: A write to index 0 clears each flag whose write-data bit is 1 and leaves each flag whose bit is 0 unchanged.
- R5: A write to index 2 sets each flag whose write-data bit is 1. Index 2 reads as 0.
- R6: While `pme_en` = 1, `prst` leaves the flags, the mask and the edge history unchanged. `grst` clears the flags, the mask, the synchronizers and the history at every edge where it is high.
- R7: While `pme_en` = 0, `prst` clears the flags, the mask and the edge history. Any input that is then high is seen as a change on the following edges.
- R8: On the edge where `card_rst` is first sampled low after being high, flags 0, 1 and 2 are set if the synchronized status-change, card-detect-1 or card-detect-2 level is 1. Card detect counts as active high.
- R9: `irq` is 1 exactly when at least one flag is set whose mask bit (index 1, bit i for flag i) is 1.
- R10: If a hardware-detected change and a write-1-to-clear reach the same flag on the same edge, the flag ends up set.
- R11: A read request (`rd_en`) sampled on an edge yields `rd_vld` = 1 and the word as it stood before that edge. Index 3 holds the synchronized levels in bit order {power, card detect 2, card detect 1, status change}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| grst | input | 1 | Global reset, synchronous, active high |
| prst | input | 1 | Bus reset, synchronous, active high, gated by `pme_en` |
| pme_en | input | 1 | Power-management enable; when 1, flags survive `prst` |
| card_is_cb | input | 1 | 1 = 32-bit bus-mastering card, 0 = 16-bit card |
| card_rst | input | 1 | Card reset, synchronous, active high |
| stat_pwr | input | 1 | Power-cycle status level, asynchronous |
| stat_cd2 | input | 1 | Card-detect-2 level, asynchronous, active high |
| stat_cd1 | input | 1 | Card-detect-1 level, asynchronous, active high |
| stat_chg | input | 1 | Card status-change level, asynchronous |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 2 | Word index (0 event, 1 mask, 2 force, 3 levels) |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_vld | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Interrupt: any set and unmasked flag |

## Verification
The assertions assume that `prst`, `card_rst`, `pme_en`, `card_is_cb` and the port signals are synchronous to `clk`. They also assume that every status level is held for at least one full cycle, since a shorter pulse may be lost in the synchronizer before it is ever compared. The bench changes every input on the falling edge only. In the directed part it holds each status level for several cycles. In the mixed random phase it changes a level at most once per cycle and keeps `grst` low. It raises `prst` and toggles `card_rst` only rarely, so that ordinary edge detection and clearing are exercised between those resets.

// File: rtl/sock_evt_pkg.sv
package sock_evt_pkg;

    localparam int NSRC   = 4;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 2;

    localparam int BIT_CHG = 0;
    localparam int BIT_CD1 = 1;
    localparam int BIT_CD2 = 2;
    localparam int BIT_PWR = 3;

    typedef logic [NSRC-1:0] evt_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_EVENT = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_FORCE = 2'd2,
        SEL_LEVEL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
        evt_vec_t data;
    } wr_req_t;

    // flags that are raised again when the card leaves its reset
    localparam evt_vec_t REARM_SET =
        evt_vec_t'((1 << BIT_CHG) | (1 << BIT_CD1) | (1 << BIT_CD2));

    // change detector: every line on both edges, the status-change line
    // optionally on rising edges only
    function automatic evt_vec_t detect_changes(evt_vec_t cur, evt_vec_t prev,
                                                logic rise_only_chg);
        evt_vec_t d;
        d = cur ^ prev;
        if (rise_only_chg)
            d[BIT_CHG] = cur[BIT_CHG] & ~prev[BIT_CHG];
        return d;
    endfunction

    // per-word write decode
    function automatic evt_vec_t write_hits(wr_req_t r, reg_sel_e s);
        return (r.wr && r.sel == s) ? r.data : '0;
    endfunction

    function automatic logic [REG_W-1:0] widen(evt_vec_t v);
        return {{(REG_W-NSRC){1'b0}}, v};
    endfunction

endpackage

// File: rtl/sock_evt_sync.sv
module sock_evt_sync
    import sock_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     grst,
    input  logic     hist_clr,
    input  logic     card_is_cb,
    input  logic     card_rst,
    input  evt_vec_t lvl_async,
    output evt_vec_t lvl_sync,
    output evt_vec_t hw_set
);

    localparam int LAST = SYNC_STAGES - 1;

    evt_vec_t hist;
    logic     crst_q;
    logic     reset_exit;

    for (genvar g = 0; g < NSRC; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (grst)
                chain <= '0;
            else
                chain <= {chain[LAST-1:0], lvl_async[g]};
        end
        assign lvl_sync[g] = chain[LAST];
    end

    always_ff @(posedge clk) begin
        if (hist_clr) begin
            hist   <= '0;
            crst_q <= 1'b0;
        end else begin
            hist   <= lvl_sync;
            crst_q <= card_rst;
        end
    end

    assign reset_exit = crst_q & ~card_rst;

    always_comb begin
        hw_set = detect_changes(lvl_sync, hist, card_is_cb);
        if (reset_exit)
            hw_set = hw_set | (lvl_sync & REARM_SET);
    end

    // R3: with a 32-bit card, a falling status-change line alone sets nothing
    a_r3_cb_no_fall: assert property (@(posedge clk) disable iff (hist_clr)
        (card_is_cb && !reset_exit && $fell(lvl_sync[BIT_CHG])) |-> !hw_set[BIT_CHG]);

    // R8: leaving card reset with a card present re-raises its detect flag
    a_r8_rearm_cd1: assert property (@(posedge clk) disable iff (hist_clr)
        ($past(card_rst) && !card_rst && lvl_sync[BIT_CD1]) |-> hw_set[BIT_CD1]);

endmodule

// File: rtl/sock_evt_flags.sv
module sock_evt_flags
    import sock_evt_pkg::*;
(
    input  logic     clk,
    input  logic     flag_clr,
    input  evt_vec_t hw_set,
    input  evt_vec_t frc_set,
    input  evt_vec_t w1c,
    output evt_vec_t flags
);

    // set sources are OR-ed last so a set always beats a same-cycle clear
    always_ff @(posedge clk) begin
        if (flag_clr)
            flags <= '0;
        else
            flags <= (flags & ~w1c) | hw_set | frc_set;
    end

    // R4: a clear with no competing set empties the flag
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (flag_clr)
        (|(w1c & ~hw_set & ~frc_set)) |=>
            ((flags & $past(w1c & ~hw_set & ~frc_set)) == '0));

    // R5: a forced bit is set on the next cycle
    a_r5_force_sets: assert property (@(posedge clk) disable iff (flag_clr)
        (|frc_set) |=> ((flags & $past(frc_set)) == $past(frc_set)));

    // R10: hardware set wins over a same-cycle clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (flag_clr)
        (|(hw_set & w1c)) |=> ((flags & $past(hw_set & w1c)) == $past(hw_set & w1c)));

endmodule

// File: rtl/sock_evt_regport.sv
module sock_evt_regport
    import sock_evt_pkg::*;
(
    input  logic              clk,
    input  logic              grst,
    input  logic              cfg_clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rd_en,
    input  evt_vec_t          flags,
    input  evt_vec_t          lvl_sync,
    output evt_vec_t          w1c,
    output evt_vec_t          frc_set,
    output evt_vec_t          mask,
    output logic              rd_vld,
    output logic [REG_W-1:0]  rd_data
);

    wr_req_t          req;
    reg_sel_e         sel;
    logic [REG_W-1:0] rd_word;
    logic             unused_wdata_hi;

    assign sel             = reg_sel_e'(addr);
    assign req             = '{wr: wr_en, sel: sel, data: wdata[NSRC-1:0]};
    assign unused_wdata_hi = ^wdata[REG_W-1:NSRC];

    assign w1c     = write_hits(req, SEL_EVENT);
    assign frc_set = write_hits(req, SEL_FORCE);

    always_ff @(posedge clk) begin
        if (cfg_clr)
            mask <= '0;
        else if (req.wr && req.sel == SEL_MASK)
            mask <= req.data;
    end

    always_comb begin
        unique case (sel)
            SEL_EVENT: rd_word = widen(flags);
            SEL_MASK:  rd_word = widen(mask);
            SEL_LEVEL: rd_word = widen(lvl_sync);
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (grst) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en)
                rd_data <= rd_word;
        end
    end

    // R1: reserved read bits stay zero
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (grst)
        rd_vld |-> (rd_data[REG_W-1:NSRC] == '0));

    // R11: a read request returns data one cycle later
    a_r11_rd_latency: assert property (@(posedge clk) disable iff (grst)
        rd_en |=> rd_vld);

endmodule

// File: rtl/sock_evt_reg.sv
module sock_evt_reg
    import sock_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              grst,
    input  logic              prst,
    input  logic              pme_en,
    input  logic              card_is_cb,
    input  logic              card_rst,
    input  logic              stat_pwr,
    input  logic              stat_cd2,
    input  logic              stat_cd1,
    input  logic              stat_chg,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rd_en,
    output logic              rd_vld,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq
);

    evt_vec_t lvl_async;
    evt_vec_t lvl_sync;
    evt_vec_t hw_set;
    evt_vec_t frc_set;
    evt_vec_t w1c;
    evt_vec_t flags;
    evt_vec_t mask;
    logic     flag_clr;

    always_comb begin
        lvl_async          = '0;
        lvl_async[BIT_CHG] = stat_chg;
        lvl_async[BIT_CD1] = stat_cd1;
        lvl_async[BIT_CD2] = stat_cd2;
        lvl_async[BIT_PWR] = stat_pwr;
    end

    // bus reset is ignored by the flags while power management is on
    assign flag_clr = grst | (prst & ~pme_en);

    sock_evt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .grst       (grst),
        .hist_clr   (flag_clr),
        .card_is_cb (card_is_cb),
        .card_rst   (card_rst),
        .lvl_async  (lvl_async),
        .lvl_sync   (lvl_sync),
        .hw_set     (hw_set)
    );

    sock_evt_flags u_flags (
        .clk      (clk),
        .flag_clr (flag_clr),
        .hw_set   (hw_set),
        .frc_set  (frc_set),
        .w1c      (w1c),
        .flags    (flags)
    );

    sock_evt_regport u_port (
        .clk      (clk),
        .grst     (grst),
        .cfg_clr  (flag_clr),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rd_en    (rd_en),
        .flags    (flags),
        .lvl_sync (lvl_sync),
        .w1c      (w1c),
        .frc_set  (frc_set),
        .mask     (mask),
        .rd_vld   (rd_vld),
        .rd_data  (rd_data)
    );

    assign irq = |(flags & mask);

    // R6: with power management on, bus reset drops no flag
    a_r6_pme_keeps: assert property (@(posedge clk) disable iff (grst)
        (prst && pme_en && w1c == '0) |=> ((flags & $past(flags)) == $past(flags)));

    // R7: with power management off, bus reset empties the flags
    a_r7_prst_clears: assert property (@(posedge clk) disable iff (grst)
        (prst && !pme_en) |=> (flags == '0));

    // R9: a fully masked register never interrupts
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (grst)
        (mask == '0) |-> !irq);

endmodule

// File: tb/sock_evt_reg_test.sv
module sock_evt_reg_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        grst = 1'b1, prst = 1'b0, pme_en = 1'b0, card_is_cb = 1'b0, card_rst = 1'b0;
    logic        stat_pwr = 1'b0, stat_cd2 = 1'b0, stat_cd1 = 1'b0, stat_chg = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic        rd_vld, irq;
    logic [31:0] rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    sock_evt_reg uut (
        .clk(clk), .grst(grst), .prst(prst), .pme_en(pme_en), .card_is_cb(card_is_cb),
        .card_rst(card_rst), .stat_pwr(stat_pwr), .stat_cd2(stat_cd2), .stat_cd1(stat_cd1),
        .stat_chg(stat_chg), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_en(rd_en),
        .rd_vld(rd_vld), .rd_data(rd_data), .irq(irq)
    );

    int    vectors = 0;
    int    errors  = 0;
    int    cycles  = 0;
    string cur_req = "R7";
    bit    started = 1'b0;
    bit    done    = 1'b0;

    // ---------------- behavioural reference ----------------
    logic [3:0] pipe[$] = '{4'h0, 4'h0};   // pipe[0] newest sample
    logic [3:0] m_hist = '0, m_flags = '0, m_mask = '0;
    logic       m_crst = 1'b0, m_vld = 1'b0;
    logic [31:0] m_rdata = '0;

    always @(posedge clk) begin
        logic [3:0] lv, seen, chg, hw, frc, clr1;
        logic       clr;
        lv   = {stat_pwr, stat_cd2, stat_cd1, stat_chg};
        seen = pipe[1];
        clr  = grst || (prst && !pme_en);
        chg  = seen ^ m_hist;
        hw   = chg;
        if (card_is_cb) hw[0] = seen[0] && !m_hist[0];
        if (m_crst && !card_rst) hw[2:0] = hw[2:0] | seen[2:0];
        frc  = (wr_en && addr == 2'd2) ? wdata[3:0] : 4'h0;
        clr1 = (wr_en && addr == 2'd0) ? wdata[3:0] : 4'h0;
        if (grst) begin
            m_vld = 1'b0; m_rdata = '0;
        end else begin
            m_vld = rd_en;
            if (rd_en)
                case (addr)
                    2'd0: m_rdata = {28'h0, m_flags};
                    2'd1: m_rdata = {28'h0, m_mask};
                    2'd2: m_rdata = 32'h0;
                    default: m_rdata = {28'h0, seen};
                endcase
        end
        if (clr) begin
            m_flags = '0; m_mask = '0; m_hist = '0; m_crst = 1'b0;
        end else begin
            m_flags = (m_flags & ~clr1) | hw | frc;
            if (wr_en && addr == 2'd1) m_mask = wdata[3:0];
            m_hist = seen;
            m_crst = card_rst;
        end
        if (grst) pipe = '{4'h0, 4'h0};
        else begin
            pipe.push_front(lv);
            void'(pipe.pop_back());
        end
        started = 1'b1;
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            vectors++;
            if (irq !== (|(m_flags & m_mask))) begin
                errors++;
                $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, |(m_flags & m_mask));
            end
            if (rd_vld !== m_vld) begin
                errors++;
                $display("FAIL R11 rd_vld actual=%b expected=%b", rd_vld, m_vld);
            end else if (m_vld && rd_data !== m_rdata) begin
                errors++;
                $display("FAIL %s rd_data actual=%h expected=%h", cur_req, rd_data, m_rdata);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step(1);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_expect(logic [1:0] a, logic [31:0] exp, string req);
        rd_en = 1'b1; addr = a;
        step(1);
        rd_en = 1'b0;
        vectors++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s read idx %0d actual=%h expected=%h", req, a, rd_data, exp);
        end
    endtask

    task automatic irq_expect(logic exp, string req);
        vectors++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
        end
    endtask

    initial begin
        step(3);
        grst = 1'b0;
        cur_req = "R7";
        rd_expect(2'd0, 32'h0, "R7");
        rd_expect(2'd1, 32'h0, "R7");

        cur_req = "R2";
        stat_pwr = 1'b1; step(4);
        rd_expect(2'd0, 32'h8, "R2");
        wr(2'd0, 32'h8);
        stat_pwr = 1'b0; step(4);
        rd_expect(2'd0, 32'h8, "R2");
        wr(2'd0, 32'hF);
        stat_cd1 = 1'b1; step(4);
        rd_expect(2'd0, 32'h2, "R2");
        wr(2'd0, 32'h2);
        stat_cd2 = 1'b1; step(4);
        rd_expect(2'd0, 32'h4, "R2");
        wr(2'd0, 32'h4);

        cur_req = "R4";
        wr(2'd2, 32'hF);
        wr(2'd0, 32'h0);
        rd_expect(2'd0, 32'hF, "R4");
        wr(2'd0, 32'h5);
        rd_expect(2'd0, 32'hA, "R4");
        wr(2'd0, 32'hF);
        rd_expect(2'd0, 32'h0, "R4");

        cur_req = "R3";
        card_is_cb = 1'b1;
        stat_chg = 1'b1; step(4);
        rd_expect(2'd0, 32'h1, "R3");
        wr(2'd0, 32'h1);
        stat_chg = 1'b0; step(4);
        rd_expect(2'd0, 32'h0, "R3");
        card_is_cb = 1'b0;
        stat_chg = 1'b1; step(4);
        wr(2'd0, 32'h1);
        stat_chg = 1'b0; step(4);
        rd_expect(2'd0, 32'h1, "R3");
        wr(2'd0, 32'h1);

        cur_req = "R5";
        wr(2'd2, 32'h3);
        rd_expect(2'd0, 32'h3, "R5");
        rd_expect(2'd2, 32'h0, "R5");
        cur_req = "R1";
        wr(2'd2, 32'hFFFF_FFF0);
        wr(2'd0, 32'hFFFF_FFF0);
        rd_expect(2'd0, 32'h3, "R1");
        wr(2'd1, 32'hFFFF_FFF0);
        rd_expect(2'd1, 32'h0, "R1");
        wr(2'd0, 32'hF);

        cur_req = "R9";
        wr(2'd2, 32'h4);
        irq_expect(1'b0, "R9");
        wr(2'd1, 32'h4);
        irq_expect(1'b1, "R9");
        wr(2'd1, 32'h3);
        irq_expect(1'b0, "R9");
        wr(2'd0, 32'hF);

        cur_req = "R11";
        stat_chg = 1'b1; stat_cd1 = 1'b0; stat_cd2 = 1'b1; stat_pwr = 1'b0;
        step(4);
        wr(2'd0, 32'hF);
        rd_expect(2'd3, 32'h5, "R11");

        cur_req = "R8";
        card_rst = 1'b1;
        stat_cd1 = 1'b1; step(4);
        wr(2'd0, 32'hF);
        rd_expect(2'd0, 32'h0, "R8");
        card_rst = 1'b0; step(1);
        rd_expect(2'd0, 32'h7, "R8");
        wr(2'd0, 32'hF);

        cur_req = "R10";
        stat_cd1 = 1'b0;
        step(2);
        wr(2'd0, 32'h2);
        rd_expect(2'd0, 32'h2, "R10");
        wr(2'd0, 32'hF);

        cur_req = "R6";
        pme_en = 1'b1;
        wr(2'd1, 32'h1);
        wr(2'd2, 32'h9);
        prst = 1'b1; step(1); prst = 1'b0;
        rd_expect(2'd0, 32'h9, "R6");
        rd_expect(2'd1, 32'h1, "R6");
        irq_expect(1'b1, "R6");
        grst = 1'b1; step(1); grst = 1'b0;
        rd_expect(2'd0, 32'h0, "R6");
        step(6);

        cur_req = "R7";
        pme_en = 1'b0;
        wr(2'd0, 32'hF);
        wr(2'd1, 32'h2);
        wr(2'd2, 32'h8);
        prst = 1'b1; step(1); prst = 1'b0;
        rd_expect(2'd0, 32'h0, "R7");
        rd_expect(2'd0, 32'h5, "R7");
        rd_expect(2'd1, 32'h0, "R7");

        cur_req = "R10";
        for (int i = 0; i < 400; i++) begin
            {stat_pwr, stat_cd2, stat_cd1, stat_chg} = 4'($urandom);
            wr_en      = 1'($urandom);
            rd_en      = 1'($urandom);
            addr       = 2'($urandom);
            wdata      = $urandom;
            card_is_cb = ($urandom % 8) == 0 ? ~card_is_cb : card_is_cb;
            card_rst   = ($urandom % 16) == 0 ? ~card_rst : card_rst;
            pme_en     = ($urandom % 32) == 0 ? ~pme_en : pme_en;
            prst       = ($urandom % 40) == 0;
            step(1);
        end
        wr_en = 1'b0; rd_en = 1'b0; prst = 1'b0;
        step(4);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule